// File: doc/BRIEF.md
# I2C Channel-Select Controller with Interrupt Reporting

This block is an I2C target that steers one of four downstream bus segments and gathers interrupt requests from them. A bus master addresses it with a 7-bit address. The upper four bits of that address are fixed at `1110` and the lower three come from strap pins. The master then writes a control byte or reads a status byte. The design registers the raw SCL and SDA levels on a fast system clock and finds START, STOP and clock edges from the registered samples. It answers by pulling SDA low through an open-drain enable.

The written control nibble does not reach the channel enables straight away. It is held as a pending value and takes effect only when a STOP condition is seen, so a segment is connected only while the bus is idle-high. Four active-low interrupt inputs are merged into one active-low output. They are also returned, inverted, in the upper half of every byte read. Each downstream channel is modelled as a single enable line.

Top module: `i2c_chansel_ctrl`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal `1110` followed by `addr_pins_i[2:0]`. On any other address it pulls SDA for no part of that transfer and changes no state.
- R2: Every complete data byte of a write transfer replaces the pending control nibble (bits 3:0), and when several bytes arrive the last one wins.
- R3: The enables are decoded from the active nibble. When bit 2 is 1, exactly `chan_en_o[bits 1:0]` is high. When bit 2 is 0, all enables are low. Bit 3 has no effect on the enables.
- R4: The enables change only after a STOP condition. A write that has been acknowledged but not yet stopped leaves them as they were.
- R5: After reset all enables are low, SDA is released and the pending nibble reads back as zero.
- R6: A read byte is sent MSB first. Bits 7:4 hold the inverse of `irq_n_i[3:0]`, sampled as each byte starts, and bits 3:0 hold the pending nibble including bit 3.
- R7: During a read, an acknowledge from the master makes the block send another freshly sampled byte. A not-acknowledge makes it release SDA and leave the transfer.
- R8: `irq_n_o` is low exactly when any `irq_n_i` bit is low, whatever the channel selection.
- R9: A repeated START or a STOP in the middle of a byte abandons that byte without storing it and returns to address reception.
- R10: The block acknowledges each complete written byte by pulling SDA low during the ninth clock, and it changes SDA only while SCL is low, except when a START or STOP resets the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired-AND of all drivers) |
| addr_pins_i | input | 3 | Strap bits forming the low address bits |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| irq_n_i | input | 4 | Active-low interrupt request per channel |
| irq_n_o | output | 1 | Active-low merged interrupt |
| chan_en_o | output | 4 | One-hot downstream channel enables |

## Verification
A wrong bit count or state in the transfer engine shows at the ports within the same byte. An acknowledge arrives in the wrong clock or never, or a read byte comes back shifted, and the bench samples SDA on every SCL high phase. A wrong pending or active selection shows either as enables that move before STOP or as a wrong enable pattern a few system cycles after STOP. It also shows in the low nibble of the next read. Random control bytes, byte counts, address misses and interrupt patterns are mixed with directed aborts and multi-byte reads, so that every state is entered with both prior histories.

// File: rtl/i2cmux_pkg.sv
package i2cmux_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } slv_state_e;
endpackage

// File: rtl/i2cmux_sync.sv
module i2cmux_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= RST_VAL;
        else        stg_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= RST_VAL;
        else        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/i2cmux_bus_cond.sv
module i2cmux_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_det,
  output logic stop_det,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign start_det = scl_s && scl_q && sda_q && !sda_s;
  assign stop_det  = scl_s && scl_q && !sda_q && sda_s;
  assign scl_rise  = scl_s && !scl_q;
  assign scl_fall  = !scl_s && scl_q;

  // R9: START and STOP can never be reported in the same cycle
  p_cond_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_det && stop_det));
endmodule

// File: rtl/i2cmux_slave_fsm.sv
module i2cmux_slave_fsm
  import i2cmux_pkg::*;
#(
  parameter logic [3:0] DEV_ID = 4'b1110,
  parameter int         LOW_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic [2:0]        addr_pins,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              sda_oe,
  output logic              wr_stb,
  output logic [LOW_W-1:0]  wr_low
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  slv_state_e        state_q, state_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              oe_q, oe_d;
  logic              addr_hit;

  assign addr_hit = (sh_q[BYTE_W-1:1] == {DEV_ID, addr_pins});

  always_comb begin
    state_d = state_q;
    sh_d    = sh_q;
    cnt_d   = cnt_q;
    oe_d    = oe_q;
    wr_stb  = 1'b0;
    if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (start_det) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_ADDR, ST_WR: begin
          if (scl_rise && cnt_q < CNT_FULL) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            if (state_q == ST_WR) begin
              state_d = ST_WR_ACK;
              oe_d    = 1'b1;
              wr_stb  = 1'b1;
            end else if (addr_hit) begin
              state_d = ST_ADDR_ACK;
              oe_d    = 1'b1;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (sh_q[0]) begin
              state_d = ST_RD;
              sh_d    = rd_byte;
              oe_d    = !rd_byte[BYTE_W-1];
            end else begin
              state_d = ST_WR;
              oe_d    = 1'b0;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            state_d = ST_WR;
            cnt_d   = '0;
            oe_d    = 1'b0;
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (cnt_q == CNT_LAST) begin
              state_d = ST_RD_ACK;
              oe_d    = 1'b0;
            end else begin
              sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
              cnt_d = cnt_q + 1'b1;
              oe_d  = !sh_q[BYTE_W-2];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            if (sda_s) state_d = ST_IDLE;
            else       cnt_d   = CNT_FULL;
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            state_d = ST_RD;
            cnt_d   = '0;
            sh_d    = rd_byte;
            oe_d    = !rd_byte[BYTE_W-1];
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      oe_q    <= oe_d;
    end
  end

  assign sda_oe = oe_q;
  assign wr_low = sh_q[LOW_W-1:0];

  // R7: outside a transfer the block never pulls SDA
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !sda_oe);

  // R9: a START always restarts address reception from bit zero
  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det) |=> (state_q == ST_ADDR && cnt_q == '0));

  // R10: SDA drive changes only while SCL is low, unless START/STOP reset it
  p_sda_low_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_det || stop_det)) |-> !scl_s);

  // R10: a written byte is acknowledged in the ninth clock
  p_wr_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> sda_oe);
endmodule

// File: rtl/i2cmux_sel_reg.sv
module i2cmux_sel_reg #(
  parameter int NUM_CH = 4,
  parameter int LOW_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [LOW_W-1:0]  wr_low,
  input  logic              stop_det,
  output logic [LOW_W-1:0]  pend_low,
  output logic [NUM_CH-1:0] chan_en
);
  localparam int SEL_W = $clog2(NUM_CH);
  localparam int ACT_W = SEL_W + 1;

  logic [LOW_W-1:0] pend_q;
  logic [ACT_W-1:0] act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_q <= '0;
    else if (wr_stb) pend_q <= wr_low;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        act_q <= '0;
    else if (stop_det) act_q <= pend_q[ACT_W-1:0];
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
    assign chan_en[g] = act_q[SEL_W] && (act_q[SEL_W-1:0] == SEL_W'(g));
  end

  assign pend_low = pend_q;

  // R3: at most one channel is ever enabled
  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_en));

  // R4: the enables move only in the cycle after a STOP
  p_hold_until_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_det |=> $stable(chan_en));
endmodule

// File: rtl/i2c_chansel_ctrl.sv
module i2c_chansel_ctrl
  import i2cmux_pkg::*;
#(
  parameter int         NUM_CH      = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_ID      = 4'b1110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        addr_pins_i,
  output logic              sda_oe_o,
  input  logic [NUM_CH-1:0] irq_n_i,
  output logic              irq_n_o,
  output logic [NUM_CH-1:0] chan_en_o
);
  localparam int LOW_W = BYTE_W - NUM_CH;

  logic             scl_s, sda_s;
  logic [NUM_CH-1:0] irq_s;
  logic             start_det, stop_det, scl_rise, scl_fall;
  logic             wr_stb;
  logic [LOW_W-1:0] wr_low, pend_low;
  logic [BYTE_W-1:0] rd_byte;

  i2cmux_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s})
  );

  i2cmux_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES), .RST_VAL({NUM_CH{1'b1}})) u_irq_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_n_i), .q(irq_s)
  );

  i2cmux_bus_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .start_det(start_det), .stop_det(stop_det),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  assign rd_byte = {~irq_s, pend_low};

  i2cmux_slave_fsm #(.DEV_ID(DEV_ID), .LOW_W(LOW_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .start_det(start_det), .stop_det(stop_det),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .addr_pins(addr_pins_i), .rd_byte(rd_byte),
    .sda_oe(sda_oe_o), .wr_stb(wr_stb), .wr_low(wr_low)
  );

  i2cmux_sel_reg #(.NUM_CH(NUM_CH), .LOW_W(LOW_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_low(wr_low),
    .stop_det(stop_det), .pend_low(pend_low), .chan_en(chan_en_o)
  );

  assign irq_n_o = &irq_n_i;
endmodule

// File: tb/i2c_chansel_ctrl_bench.sv
module i2c_chansel_ctrl_bench;
  localparam int Q = 6;
  localparam logic [2:0] PINS = 3'b101;
  localparam logic [6:0] MY_ADDR = {4'b1110, PINS};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [3:0] irq_n = 4'hF;
  logic sda_oe, irq_out_n;
  logic [3:0] chan_en;
  logic sda_line;
  int unsigned checks = 0;
  int unsigned fails = 0;
  bit done = 1'b0;
  logic [3:0] exp_pend = 4'h0;
  logic [3:0] exp_act = 4'h0;

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_chansel_ctrl u_i2c_chansel_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_pins_i(PINS), .sda_oe_o(sda_oe), .irq_n_i(irq_n),
    .irq_n_o(irq_out_n), .chan_en_o(chan_en)
  );

  function automatic logic [3:0] exp_en(input logic [3:0] c);
    return c[2] ? (4'b0001 << c[1:0]) : 4'b0000;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [3:0] irqv, input logic [3:0] p);
    return {~irqv, p};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      sda_m = b[i]; wq(Q);
      scl_m = 1'b1; wq(2 * Q);
      scl_m = 1'b0; wq(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    ack = !sda_line; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wq(Q);
      scl_m = 1'b1; wq(Q);
      b[i] = sda_line; wq(Q);
      scl_m = 1'b0; wq(Q);
    end
  endtask

  task automatic master_ack(input logic a);
    sda_m = !a; wq(Q);
    scl_m = 1'b1; wq(2 * Q);
    scl_m = 1'b0; wq(Q);
    sda_m = 1'b1;
  endtask

  task automatic read_once(input string req);
    logic ack;
    logic [7:0] b;
    bus_start();
    send_byte({MY_ADDR, 1'b1}, ack);
    chk({req, " R1 read addr ack"}, ack, 1'b1);
    recv_byte(b);
    chk({req, " R6 read byte"}, b, exp_rd(irq_n, exp_pend));
    master_ack(1'b0);
    wq(Q);
    chk({req, " R7 released after nack"}, sda_oe, 1'b0);
    bus_stop();
    exp_act = exp_pend;
  endtask

  task automatic write_txn(input logic [6:0] a, input logic [7:0] d0, input logic [7:0] d1,
                           input logic [7:0] d2, input int n, input string req);
    logic ack;
    logic [7:0] dv [3];
    logic hit;
    dv[0] = d0; dv[1] = d1; dv[2] = d2;
    hit = (a == MY_ADDR);
    bus_start();
    send_byte({a, 1'b0}, ack);
    chk({req, " R1 addr ack"}, ack, hit);
    for (int k = 0; k < n; k++) begin
      send_byte(dv[k], ack);
      chk({req, " R10 data ack"}, ack, hit);
      if (hit) exp_pend = dv[k][3:0];
    end
    chk({req, " R4 no change before stop"}, chan_en, exp_en(exp_act));
    bus_stop();
    wq(Q);
    exp_act = exp_pend;
    chk({req, " R3 enables after stop"}, chan_en, exp_en(exp_act));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] b;
    void'($urandom(32'd2024));
    wq(5);
    rst_n = 1'b1;
    wq(Q);
    // R5 reset state
    chk("R5 enables at reset", chan_en, 4'h0);
    chk("R5 sda released at reset", sda_oe, 1'b0);
    chk("R8 irq idle", irq_out_n, 1'b1);
    read_once("R5 reset readback");

    write_txn(MY_ADDR, 8'h05, 8'h00, 8'h00, 1, "ch1 select");
    write_txn(MY_ADDR, 8'h09, 8'h00, 8'h00, 1, "R3 disable bit3 ignored");
    write_txn(MY_ADDR, 8'h04, 8'h06, 8'h07, 3, "R2 last byte wins");
    write_txn(MY_ADDR ^ 7'h01, 8'h04, 8'h00, 8'h00, 1, "R1 wrong addr");
    write_txn({4'b1111, PINS}, 8'h05, 8'h00, 8'h00, 1, "R1 wrong fixed bits");
    write_txn(MY_ADDR, 8'h0E, 8'h00, 8'h00, 1, "R6 bit3 stored");
    read_once("R6 bit3 readback");

    // R8 merged interrupt, independent of selection
    irq_n = 4'b1010; wq(2);
    chk("R8 irq low when any low", irq_out_n, 1'b0);
    irq_n = 4'b0111; wq(2);
    chk("R8 irq low on ch3", irq_out_n, 1'b0);
    irq_n = 4'hF; wq(2);
    chk("R8 irq released", irq_out_n, 1'b1);

    // R6/R7 two-byte read with interrupt change between bytes
    irq_n = 4'b1010; wq(Q);
    bus_start();
    send_byte({MY_ADDR, 1'b1}, ack);
    chk("R1 read addr ack", ack, 1'b1);
    recv_byte(b);
    chk("R6 first byte", b, exp_rd(4'b1010, exp_pend));
    irq_n = 4'b0101;
    master_ack(1'b1);
    recv_byte(b);
    chk("R7 second byte after ack", b, exp_rd(4'b0101, exp_pend));
    master_ack(1'b0);
    wq(Q);
    chk("R7 released after nack", sda_oe, 1'b0);
    bus_stop();
    irq_n = 4'hF;

    // R9 partial byte abort by repeated START
    bus_start();
    send_byte({MY_ADDR, 1'b0}, ack);
    send_byte(8'h04, ack);
    exp_pend = 4'h4;
    send_bits(8'h07, 4);
    bus_start();
    send_byte({MY_ADDR, 1'b1}, ack);
    chk("R9 addr ack after restart", ack, 1'b1);
    recv_byte(b);
    chk("R9 partial byte dropped", b, exp_rd(4'hF, 4'h4));
    master_ack(1'b0);
    bus_stop();
    wq(Q);
    exp_act = exp_pend;
    chk("R9 enables after abort", chan_en, exp_en(exp_act));

    // R9 STOP mid-byte
    bus_start();
    send_byte({MY_ADDR, 1'b0}, ack);
    send_bits(8'h06, 3);
    bus_stop();
    wq(Q);
    chk("R9 stop mid-byte keeps selection", chan_en, exp_en(exp_act));

    // random mix
    for (int it = 0; it < 30; it++) begin
      logic [6:0] a;
      int n;
      a = MY_ADDR;
      if (($urandom % 5) == 0) a = MY_ADDR ^ 7'(1 + ($urandom % 127));
      n = 1 + int'($urandom % 3);
      irq_n = 4'($urandom);
      wq(2);
      chk("R8 random irq", irq_out_n, &irq_n);
      write_txn(a, 8'($urandom), 8'($urandom), 8'($urandom), n, "R2 random write");
      read_once("R6 random read");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule